// File: doc/BRIEF.md
# Calibrated One-Second Divider

This block turns a 32,768 Hz oscillator clock-enable into a one-per-second tick and trims the crystal error digitally. The correction works at the divide-by-256 stage. Within a repeating frame of 64 minutes, the first second of some minutes is shortened or lengthened. A magnitude N selects how many minutes are corrected: the first 2N minutes of each frame. A sign bit selects the direction. A set sign shortens the affected second by one full stage unit (256 enables). A clear sign lengthens it by half a unit (128 enables).

A halt input freezes and clears the divider, so the correction schedule restarts from a known point when counting resumes. A frequency-test input brings out a square wave taken from the raw enable stream. Its period is 64 enables, which gives 512 Hz. The calibration setting has no effect on this wave. The calendar counters that use the tick sit outside the block, and so does the register decode that supplies the control bits.

Top module: `cal_sec_divider`

## Requirements
- R1: After synchronous reset, `sec_tick`, `minute_idx` and `test_out` are all 0, and the latched calibration is zero.
- R2: With no correction in force, one second lasts 2^(PRE_W+POST_W) enabled clocks (32,768 by default). `sec_tick` is a single-clock pulse, asserted in the clock after the edge that consumes the last enable of the second.
- R3: Only clocks with `osc_en` high advance the divider. Gaps in the enable stream stretch the second in clock time but leave its length in enables unchanged.
- R4: `minute_idx` counts minutes of the frame from 0 to 2^(CAL_W+1)-1 and then wraps to 0. It advances on every SEC_PER_MIN-th tick and changes at no other time, except when it is cleared.
- R5: With the latched sign at 1, the first second of each minute whose index is below 2N lasts 2^PRE_W fewer enables than nominal (256 fewer by default).
- R6: With the latched sign at 0, the first second of each minute whose index is below 2N lasts 2^(PRE_W-1) more enables than nominal (128 more by default).
- R7: Every other second keeps the nominal length. This covers seconds other than the first in a minute, minutes with index 2N or more, and every second when N = 0.
- R8: `cal_mag` and `cal_fast` are sampled only at the edge where the frame wraps from its last minute to minute 0, or on any clock while `halt` is high. A change made partway through a frame acts only from the next frame.
- R9: While `halt` is high, no tick is produced, and the stage counter, second counter and minute counter are held at 0. After `halt` falls, the first tick arrives exactly one second of enables later, with the correction that applies to minute 0, second 0.
- R10: When `ftest` is 1 and `halt` is 0, `test_out` is bit TST_W-1 of a counter of enables. It is cleared while halted, and its period is 2^TST_W enables (512 Hz by default) whatever the calibration. Otherwise `test_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One-clock enable per oscillator period |
| halt | input | 1 | Stop control; clears and holds the divider |
| ftest | input | 1 | Frequency-test select |
| cal_fast | input | 1 | Correction sign: 1 shortens, 0 lengthens |
| cal_mag | input | CAL_W | Correction magnitude N |
| sec_tick | output | 1 | One-clock pulse per second |
| minute_idx | output | CAL_W+1 | Minute position inside the correction frame |
| test_out | output | 1 | Frequency-test square wave |

## Verification
The divider is exercised with scaled parameters. It first runs with magnitude zero, which fixes the nominal length. It then runs positive and negative settings, which separate the shortened second from the lengthened one and confirm that only the first 2N minutes are touched. A calibration change made mid-frame shows whether the new value waits for the frame boundary. A sparse enable pattern shows that idle clocks are not counted. Halt windows with the test output selected check that ticks and the wave stay quiet, and that the schedule restarts from minute 0.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    // Correction applied to the second currently being counted
    typedef enum logic [1:0] {
        CORR_NONE = 2'd0,
        CORR_FAST = 2'd1,
        CORR_SLOW = 2'd2
    } corr_e;

    function automatic corr_e pick_corr(input logic active, input logic fast);
        if (!active)
            return CORR_NONE;
        return fast ? CORR_FAST : CORR_SLOW;
    endfunction

endpackage

// File: rtl/cdiv_prescale.sv
module cdiv_prescale
    import cdiv_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int POST_W = 7
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  halt,
    input  logic  osc_en,
    input  corr_e corr,
    output logic  sec_end
);
    localparam int UNIT = 1 << PRE_W;
    localparam int LONG = UNIT + UNIT / 2;
    localparam int PW   = PRE_W + 1;

    logic [PW-1:0]     pre_q, pre_last;
    logic [POST_W-1:0] post_q, step;
    logic              first_unit, unit_end;

    always_comb begin
        first_unit = (post_q == '0);
        pre_last   = (corr == CORR_SLOW && first_unit) ? PW'(LONG - 1) : PW'(UNIT - 1);
        step       = (corr == CORR_FAST && first_unit) ? POST_W'(2) : POST_W'(1);
        unit_end   = osc_en && (pre_q == pre_last);
        sec_end    = unit_end && (&post_q);
    end

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            pre_q  <= '0;
            post_q <= '0;
        end else if (osc_en) begin
            if (pre_q == pre_last) begin
                pre_q  <= '0;
                post_q <= post_q + step;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    AST_SKIP_ONLY_FAST: assert property (@(posedge clk) disable iff (rst)
        (post_q == POST_W'(2) && $past(post_q) == '0) |-> $past(corr) == CORR_FAST); // R5

    AST_LONG_ONLY_SLOW: assert property (@(posedge clk) disable iff (rst)
        (pre_q > PW'(UNIT - 1)) |-> (corr == CORR_SLOW && first_unit)); // R6

endmodule

// File: rtl/cdiv_schedule.sv
module cdiv_schedule
    import cdiv_pkg::*;
#(
    parameter int SEC_PER_MIN = 60,
    parameter int CAL_W       = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic             sec_end,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_fast,
    output corr_e            corr,
    output logic [CAL_W:0]   min_idx
);
    localparam int MIN_W = CAL_W + 1;
    localparam int SEC_W = (SEC_PER_MIN > 2) ? $clog2(SEC_PER_MIN) : 1;

    logic [SEC_W-1:0] sec_q;
    logic [MIN_W-1:0] min_q;
    logic [CAL_W-1:0] lat_mag;
    logic             lat_fast;
    logic             sec_wrap, cyc_wrap;

    always_comb begin
        sec_wrap = sec_end && (sec_q == SEC_W'(SEC_PER_MIN - 1));
        cyc_wrap = sec_wrap && (&min_q);
        corr     = pick_corr((sec_q == '0) && (min_q < {lat_mag, 1'b0}), lat_fast);
        min_idx  = min_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q    <= '0;
            min_q    <= '0;
            lat_mag  <= '0;
            lat_fast <= 1'b0;
        end else if (halt) begin
            sec_q    <= '0;
            min_q    <= '0;
            lat_mag  <= cal_mag;
            lat_fast <= cal_fast;
        end else if (sec_end) begin
            sec_q <= sec_wrap ? '0 : sec_q + 1'b1;
            if (sec_wrap)
                min_q <= min_q + 1'b1;
            if (cyc_wrap) begin
                lat_mag  <= cal_mag;
                lat_fast <= cal_fast;
            end
        end
    end

    AST_MIN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        !$stable(min_q) |-> ($past(sec_end) || $past(halt))); // R4

    AST_CAL_FRAME: assert property (@(posedge clk) disable iff (rst)
        !$stable({lat_fast, lat_mag}) |-> ($past(halt) || $past(cyc_wrap))); // R8

endmodule

// File: rtl/cdiv_ftest.sv
module cdiv_ftest #(
    parameter int TST_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic halt,
    input  logic osc_en,
    input  logic ftest,
    output logic test_out
);
    logic [TST_W-1:0] tcnt_q;

    always_ff @(posedge clk) begin
        if (rst || halt)
            tcnt_q <= '0;
        else if (osc_en)
            tcnt_q <= tcnt_q + 1'b1;
    end

    assign test_out = ftest && !halt && tcnt_q[TST_W-1];

endmodule

// File: rtl/cal_sec_divider.sv
module cal_sec_divider
    import cdiv_pkg::*;
#(
    parameter int PRE_W       = 8,
    parameter int POST_W      = 7,
    parameter int SEC_PER_MIN = 60,
    parameter int CAL_W       = 5,
    parameter int TST_W       = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_en,
    input  logic             halt,
    input  logic             ftest,
    input  logic             cal_fast,
    input  logic [CAL_W-1:0] cal_mag,
    output logic             sec_tick,
    output logic [CAL_W:0]   minute_idx,
    output logic             test_out
);
    corr_e corr;
    logic  sec_end;
    logic  tick_q;

    cdiv_prescale #(.PRE_W(PRE_W), .POST_W(POST_W)) u_pre (
        .clk(clk), .rst(rst), .halt(halt), .osc_en(osc_en),
        .corr(corr), .sec_end(sec_end)
    );

    cdiv_schedule #(.SEC_PER_MIN(SEC_PER_MIN), .CAL_W(CAL_W)) u_sched (
        .clk(clk), .rst(rst), .halt(halt), .sec_end(sec_end),
        .cal_mag(cal_mag), .cal_fast(cal_fast),
        .corr(corr), .min_idx(minute_idx)
    );

    cdiv_ftest #(.TST_W(TST_W)) u_ft (
        .clk(clk), .rst(rst), .halt(halt), .osc_en(osc_en),
        .ftest(ftest), .test_out(test_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tick_q <= 1'b0;
        else
            tick_q <= sec_end && !halt;
    end

    assign sec_tick = tick_q;

    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick); // R2

    AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        halt |=> !sec_tick); // R9

endmodule

// File: tb/cal_sec_divider_tb.sv
module cal_sec_divider_tb;
    localparam int PRE_W = 3, POST_W = 3, SPM = 4, CAL_W = 2, TST_W = 2;
    localparam int UNIT = 1 << PRE_W;
    localparam int NOM  = 1 << (PRE_W + POST_W);
    localparam int NMIN = 1 << (CAL_W + 1);

    logic clk = 1'b0, rst = 1'b1, osc_en = 1'b1, halt = 1'b1, ftest = 1'b0, cal_fast = 1'b0;
    logic [CAL_W-1:0] cal_mag = '0;
    logic sec_tick, test_out;
    logic [CAL_W:0] minute_idx;

    cal_sec_divider #(.PRE_W(PRE_W), .POST_W(POST_W), .SEC_PER_MIN(SPM),
                      .CAL_W(CAL_W), .TST_W(TST_W)) u_dut (
        .clk(clk), .rst(rst), .osc_en(osc_en), .halt(halt), .ftest(ftest),
        .cal_fast(cal_fast), .cal_mag(cal_mag), .sec_tick(sec_tick),
        .minute_idx(minute_idx), .test_out(test_out)
    );

    always #10 clk = ~clk;

    int    errors = 0, checks = 0, ticks_seen = 0, halt_ticks = 0;
    bit    saw_wrap = 1'b0, done = 1'b0;
    string cur_req = "R2";

    // behavioural reference
    int    m_cnt = 0, m_sec = 0, m_min = 0, m_mag = 0, m_fast = 0, m_tcnt = 0, len = NOM;
    bit    exp_tick = 1'b0, exp_wave;
    string tick_tag = "R2";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_sec = 0; m_min = 0; m_mag = 0; m_fast = 0; m_tcnt = 0; exp_tick = 0;
        end else if (halt) begin
            m_cnt = 0; m_sec = 0; m_min = 0; m_tcnt = 0; exp_tick = 0;
            m_mag = int'(cal_mag); m_fast = int'(cal_fast);
        end else begin
            exp_tick = 0;
            if (osc_en) begin
                m_tcnt = (m_tcnt + 1) % (1 << TST_W);
                len = NOM;
                tick_tag = cur_req;
                if (m_sec == 0 && m_min < 2 * m_mag) begin
                    len = (m_fast != 0) ? NOM - UNIT : NOM + UNIT / 2;
                    tick_tag = (m_fast != 0) ? "R5" : "R6";
                end
                m_cnt++;
                if (m_cnt == len) begin
                    m_cnt = 0; exp_tick = 1; m_sec++;
                    if (m_sec == SPM) begin
                        m_sec = 0; m_min++;
                        if (m_min == NMIN) begin
                            m_min = 0; saw_wrap = 1'b1;
                            m_mag = int'(cal_mag); m_fast = int'(cal_fast);
                        end
                    end
                end
            end
        end
        #5;
        if (!rst && !done) begin
            exp_wave = ftest && !halt && (((m_tcnt >> (TST_W - 1)) & 1) != 0);
            chk(sec_tick == exp_tick, halt ? "R9" : tick_tag, int'(sec_tick), int'(exp_tick));
            chk(minute_idx == (CAL_W+1)'(m_min), "R4", int'(minute_idx), m_min);
            chk(test_out == exp_wave, "R10", int'(test_out), int'(exp_wave));
            if (sec_tick) ticks_seen++;
            if (sec_tick && halt) halt_ticks++;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        run(4);
        chk(sec_tick == 1'b0, "R1", int'(sec_tick), 0);
        chk(minute_idx == '0, "R1", int'(minute_idx), 0);
        chk(test_out == 1'b0, "R1", int'(test_out), 0);
        rst = 1'b0;
        run(3);
        // nominal seconds, N = 0, two full frames
        cur_req = "R2"; halt = 1'b0;
        run(2 * NMIN * SPM * NOM + 200);
        chk(saw_wrap, "R4", int'(saw_wrap), 1);
        // halt window with test wave selected, then positive calibration
        cur_req = "R9"; halt = 1'b1; ftest = 1'b1; cal_mag = 2'd2; cal_fast = 1'b1;
        run(25);
        chk(halt_ticks == 0, "R9", halt_ticks, 0);
        chk(minute_idx == '0, "R9", int'(minute_idx), 0);
        chk(test_out == 1'b0, "R10", int'(test_out), 0);
        cur_req = "R7"; halt = 1'b0;
        run(NMIN * SPM * NOM + 300);
        // change mid-frame without halt: negative takes effect next frame
        cur_req = "R8"; cal_mag = 2'd3; cal_fast = 1'b0;
        run(2 * NMIN * SPM * NOM + 100);
        // sparse enables
        cur_req = "R3";
        for (int i = 0; i < 3 * SPM * NOM; i++) begin
            osc_en = (i % 3 == 0);
            @(negedge clk);
        end
        osc_en = 1'b1;
        // positive N = 1 restarted via halt
        cur_req = "R9"; halt = 1'b1; cal_mag = 2'd1; cal_fast = 1'b1;
        run(10);
        cur_req = "R7"; halt = 1'b0;
        run(NMIN * SPM * NOM + 100);
        cur_req = "R9"; halt = 1'b1;
        run(20);
        chk(halt_ticks == 0, "R9", halt_ticks, 0);
        chk(ticks_seen > 100, "R2", ticks_seen, 101);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule